// File: doc/BRIEF.md
# Processor-Side Interrupt Signalling Port

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending interrupt (ID, priority, group). The block decides whether that interrupt is urgent enough to interrupt the processor. It checks the priority against a programmable mask and against the running priority of the processor. If the interrupt passes, the block drives one of two active-low request lines after a fixed latency. Lower priority numbers are more urgent.

The processor works the block through single-cycle strobes:
- **Acknowledge read:** returns the interrupt ID and makes that interrupt active.
- **End-of-interrupt write:** performs a priority drop.
- **Deactivate write:** ends the interrupt separately, when split completion is on.
- **Pending query:** reads the best pending ID without changing any state.
- **Control write:** sets the split-completion bit and the fast-request (FIQ) bit.
- **Mask write:** sets the priority mask.

A stack of saved priorities lets nested interrupts each restore the running priority they interrupted.

The distributor offer is a valid-qualified stream with no ready. The block never applies back-pressure: the offer is sampled every cycle. The activate and deactivate notifications are one-cycle valid pulses, and the distributor must accept them in the cycle they appear.

Top module: `irqc_cpu_port`

## Requirements
- R1: After reset the state is as follows:
  - `irq_n` and `fiq_n` are 1.
  - `running_prio` is all ones.
  - The mask is 0, so nothing qualifies.
  - Split completion and fast-request select are off.
  - `ack_id` and `hppi_id` read the spurious ID (all ones, 1023).
  - No activate or deactivate pulse is issued.
- R2: An offer qualifies only when all of the following hold:
  - `hp_valid` is 1.
  - `hp_prio` is strictly below the mask.
  - `hp_prio` is strictly below `running_prio`.
  - The priority stack is not full.
  
  An offer that does not qualify never drives a request line.
- R3: A request line asserts after the 15th rising edge at which the offer has qualified without a break. Any break restarts the count. If the best offer changes while it keeps qualifying, the line stays asserted.
- R4: A pulse on `ack_rd` has one of two results:
  - **Offer qualifies:** on the next cycle `ack_id` shows `hp_id`, `act_vld` pulses with `act_id = hp_id`, and `running_prio` takes `hp_prio`.
  - **Offer does not qualify:** `ack_id` shows 1023 and no other state changes.
- R5: After an accepted acknowledge, the request line stays asserted for 3 cycles and then releases. It stays asserted beyond that only if a new offer has completed its own 15-cycle qualification.
- R6: With split completion off (bit 0 of the control write), an `eoi_wr` performs two actions on the next cycle:
  - It drops the running priority.
  - It pulses `deact_vld` with `deact_id = eoi_id`.
- R7: With split completion on, an `eoi_wr` only drops the running priority. A later `dir_wr` then pulses `deact_vld` with `deact_id = dir_id`. When split completion is off, `dir_wr` is ignored.
- R8: A priority drop restores `running_prio` to the value it held just before the matching acknowledge. This holds through nesting.
- R9: An `eoi_wr` with an empty stack is ignored: `running_prio` is unchanged and no deactivate pulse is issued. An `eoi_wr` in the same cycle as `ack_rd` is also ignored.
- R10: A group-0 offer (`hp_grp0 = 1`) drives `fiq_n` when the fast-request bit (bit 1 of the control write) is set. All other offers drive `irq_n`.
- R11: A pulse on `hppi_rd` loads `hppi_id` on the next cycle with `hp_id`, or with 1023 when `hp_valid` is 0. It changes no other state.
- R12: The stack holds 8 saved priorities. An acknowledge while the stack is full returns 1023 and leaves `running_prio` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_valid | input | 1 | Distributor offer valid |
| hp_id | input | ID_W | Offered interrupt ID |
| hp_prio | input | PW | Offered priority |
| hp_grp0 | input | 1 | Offered interrupt is group 0 |
| ctl_wr | input | 1 | Control write strobe |
| ctl_split | input | 1 | Split-completion bit (bit 0) |
| ctl_fiq_en | input | 1 | Fast-request select bit (bit 1) |
| pmr_wr | input | 1 | Mask write strobe |
| pmr_val | input | PW | New mask value |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_id | output | ID_W | Acknowledge result |
| hppi_rd | input | 1 | Pending query strobe |
| hppi_id | output | ID_W | Pending query result |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | ID_W | ID written at end-of-interrupt |
| dir_wr | input | 1 | Deactivate write strobe |
| dir_id | input | ID_W | ID written at deactivate |
| act_vld | output | 1 | Activate notification pulse |
| act_id | output | ID_W | ID to make active |
| deact_vld | output | 1 | Deactivate notification pulse |
| deact_id | output | ID_W | ID to deactivate |
| running_prio | output | PW | Current running priority |
| irq_n | output | 1 | Normal request line, active low |
| fiq_n | output | 1 | Fast request line, active low |

## Verification
The assertions take the following for granted about the inputs:
- The processor strobes are one-cycle pulses.
- The processor does not write end-of-interrupt for an interrupt it never acknowledged.
- The distributor removes or replaces an offer once the processor has acknowledged it, rather than holding it after it can no longer qualify.

The stimulus drives all strobes as single pulses on the falling edge. It issues an acknowledge only for the interrupt the test is nesting, and it pops the stack exactly as often as it pushed, apart from the deliberate end-of-interrupt on an empty stack.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Rising edges an offer must qualify before a request line asserts
  localparam int unsigned RAISE_CYCLES = 15;
  // Cycles a request line is held after an accepted acknowledge
  localparam int unsigned RELEASE_CYCLES = 3;
  // Saved-priority stack depth
  localparam int unsigned NEST_DEPTH = 8;

  typedef enum logic {
    COMPLETE_JOINT = 1'b0,
    COMPLETE_SPLIT = 1'b1
  } complete_mode_e;
endpackage

// File: rtl/irqc_prio_stack.sv
module irqc_prio_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_val,
  input  logic          pop,
  output logic [PW-1:0] top_val,
  output logic          empty,
  output logic          full
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] slot [DEPTH];
  logic [CW-1:0] used;
  logic [AW-1:0] rd_idx;

  assign empty   = (used == '0);
  assign full    = (used == CW'(DEPTH));
  assign rd_idx  = AW'(used - 1'b1);
  assign top_val = slot[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 used <= '0;
    else if (push && !full)     used <= used + 1'b1;
    else if (pop && !empty)     used <= used - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push && !full) slot[AW'(used)] <= push_val;
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R12
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R9
endmodule

// File: rtl/irqc_sig_timer.sv
module irqc_sig_timer #(
  parameter int unsigned RAISE   = 15,
  parameter int unsigned RELEASE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  input  logic ack,
  input  logic fast_now,
  output logic irq_n,
  output logic fiq_n
);
  localparam int unsigned QW = $clog2(RAISE + 1);
  localparam int unsigned HW = $clog2(RELEASE + 1);

  logic [QW-1:0] qcnt;
  logic [HW-1:0] hold;
  logic          held_fast;
  logic          live;
  logic          holding;

  assign live    = (qcnt == QW'(RAISE));
  assign holding = (hold != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt      <= '0;
      hold      <= '0;
      held_fast <= 1'b0;
    end else begin
      if (ack || !qual) qcnt <= '0;
      else if (!live)   qcnt <= qcnt + 1'b1;
      if (ack)          hold <= HW'(RELEASE);
      else if (holding) hold <= hold - 1'b1;
      if (ack)          held_fast <= fast_now;
    end
  end

  assign fiq_n = !((live && fast_now)  || (holding && held_fast));
  assign irq_n = !((live && !fast_now) || (holding && !held_fast));

  AST_RAISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |-> $past(qual));  // R3
  AST_HOLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !(irq_n && fiq_n));  // R5
endmodule

// File: rtl/irqc_cpu_port.sv
module irqc_cpu_port
  import irqc_pkg::*;
#(
  parameter int unsigned ID_W    = 10,
  parameter int unsigned PW      = 8,
  parameter int unsigned DEPTH   = NEST_DEPTH,
  parameter int unsigned RAISE   = RAISE_CYCLES,
  parameter int unsigned RELEASE = RELEASE_CYCLES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hp_valid,
  input  logic [ID_W-1:0] hp_id,
  input  logic [PW-1:0]   hp_prio,
  input  logic            hp_grp0,
  input  logic            ctl_wr,
  input  logic            ctl_split,
  input  logic            ctl_fiq_en,
  input  logic            pmr_wr,
  input  logic [PW-1:0]   pmr_val,
  input  logic            ack_rd,
  output logic [ID_W-1:0] ack_id,
  input  logic            hppi_rd,
  output logic [ID_W-1:0] hppi_id,
  input  logic            eoi_wr,
  input  logic [ID_W-1:0] eoi_id,
  input  logic            dir_wr,
  input  logic [ID_W-1:0] dir_id,
  output logic            act_vld,
  output logic [ID_W-1:0] act_id,
  output logic            deact_vld,
  output logic [ID_W-1:0] deact_id,
  output logic [PW-1:0]   running_prio,
  output logic            irq_n,
  output logic            fiq_n
);
  localparam logic [ID_W-1:0] SPURIOUS = '1;
  localparam logic [PW-1:0]   IDLE_PRIO = '1;

  complete_mode_e mode;
  logic           fiq_en;
  logic [PW-1:0]  pmr;
  logic [PW-1:0]  saved_prio;
  logic           stk_empty, stk_full;
  logic           qual, ack_ok, eoi_ok;
  logic           deact_now;

  assign qual   = hp_valid && (hp_prio < pmr) && (hp_prio < running_prio) && !stk_full;
  assign ack_ok = ack_rd && qual;
  assign eoi_ok = eoi_wr && !ack_rd && !stk_empty;
  assign deact_now = (mode == COMPLETE_JOINT) ? eoi_ok : dir_wr;

  irqc_prio_stack #(.DEPTH(DEPTH), .PW(PW)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_ok),
    .push_val (running_prio),
    .pop      (eoi_ok),
    .top_val  (saved_prio),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  irqc_sig_timer #(.RAISE(RAISE), .RELEASE(RELEASE)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .qual     (qual),
    .ack      (ack_ok),
    .fast_now (hp_grp0 && fiq_en),
    .irq_n    (irq_n),
    .fiq_n    (fiq_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode         <= COMPLETE_JOINT;
      fiq_en       <= 1'b0;
      pmr          <= '0;
      running_prio <= IDLE_PRIO;
      ack_id       <= SPURIOUS;
      hppi_id      <= SPURIOUS;
      act_vld      <= 1'b0;
      act_id       <= '0;
      deact_vld    <= 1'b0;
      deact_id     <= '0;
    end else begin
      if (ctl_wr) begin
        mode   <= complete_mode_e'(ctl_split);
        fiq_en <= ctl_fiq_en;
      end
      if (pmr_wr)  pmr <= pmr_val;
      if (ack_rd)  ack_id <= ack_ok ? hp_id : SPURIOUS;
      if (hppi_rd) hppi_id <= hp_valid ? hp_id : SPURIOUS;
      act_vld <= ack_ok;
      if (ack_ok) act_id <= hp_id;
      deact_vld <= deact_now;
      if (deact_now) deact_id <= (mode == COMPLETE_JOINT) ? eoi_id : dir_id;
      if (ack_ok)      running_prio <= hp_prio;
      else if (eoi_ok) running_prio <= saved_prio;
    end
  end

  AST_ACK_RAISES_URGENCY: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |-> (running_prio < $past(running_prio)));  // R4
  AST_REFUSED_ACK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !qual) |=> $stable(running_prio));  // R4
  AST_DROP_RESTORES_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_ok |=> (running_prio > $past(running_prio)));  // R8
  AST_DEACT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    deact_vld |-> $past(eoi_wr || dir_wr));  // R6
endmodule

// File: tb/irqc_cpu_port_tb.sv
`timescale 1ns/1ps
module irqc_cpu_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hp_valid = 0, hp_grp0 = 0;
  logic [9:0] hp_id = '0;
  logic [7:0] hp_prio = '0;
  logic       ctl_wr = 0, ctl_split = 0, ctl_fiq_en = 0;
  logic       pmr_wr = 0;
  logic [7:0] pmr_val = '0;
  logic       ack_rd = 0, hppi_rd = 0, eoi_wr = 0, dir_wr = 0;
  logic [9:0] eoi_id = '0, dir_id = '0;
  logic [9:0] ack_id, hppi_id, act_id, deact_id;
  logic       act_vld, deact_vld, irq_n, fiq_n;
  logic [7:0] running_prio;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqc_cpu_port u_dut (
    .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio),
    .hp_grp0(hp_grp0), .ctl_wr(ctl_wr), .ctl_split(ctl_split), .ctl_fiq_en(ctl_fiq_en),
    .pmr_wr(pmr_wr), .pmr_val(pmr_val), .ack_rd(ack_rd), .ack_id(ack_id),
    .hppi_rd(hppi_rd), .hppi_id(hppi_id), .eoi_wr(eoi_wr), .eoi_id(eoi_id),
    .dir_wr(dir_wr), .dir_id(dir_id), .act_vld(act_vld), .act_id(act_id),
    .deact_vld(deact_vld), .deact_id(deact_id), .running_prio(running_prio),
    .irq_n(irq_n), .fiq_n(fiq_n)
  );

  // Behavioural reference model
  int m_qcnt, m_hold, m_run, m_pmr, m_ack, m_hppi, m_acti, m_di;
  bit m_held_fast, m_split, m_fiqen, m_actv, m_dv;
  int m_stk[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_qcnt = 0; m_hold = 0; m_held_fast = 0; m_run = 255; m_pmr = 0;
      m_split = 0; m_fiqen = 0; m_ack = 1023; m_hppi = 1023;
      m_actv = 0; m_acti = 0; m_dv = 0; m_di = 0; m_stk.delete();
    end else begin
      bit q, aok, eok;
      q   = hp_valid && (int'(hp_prio) < m_pmr) && (int'(hp_prio) < m_run) && (m_stk.size() < 8);
      aok = ack_rd && q;
      eok = eoi_wr && !ack_rd && (m_stk.size() > 0);
      if (aok) m_held_fast = hp_grp0 && m_fiqen;
      m_qcnt = (aok || !q) ? 0 : ((m_qcnt < 15) ? m_qcnt + 1 : 15);
      m_hold = aok ? 3 : ((m_hold > 0) ? m_hold - 1 : 0);
      if (ack_rd)  m_ack = aok ? int'(hp_id) : 1023;
      if (hppi_rd) m_hppi = hp_valid ? int'(hp_id) : 1023;
      m_actv = aok;
      if (aok) m_acti = hp_id;
      m_dv = m_split ? dir_wr : eok;
      if (m_dv) m_di = m_split ? int'(dir_id) : int'(eoi_id);
      if (aok) begin m_stk.push_back(m_run); m_run = hp_prio; end
      else if (eok) m_run = m_stk.pop_back();
      if (ctl_wr) begin m_split = ctl_split; m_fiqen = ctl_fiq_en; end
      if (pmr_wr) m_pmr = pmr_val;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    bit live, fast;
    live = (m_qcnt == 15);
    fast = hp_grp0 && m_fiqen;
    chk("R3 irq_n model", int'(irq_n), int'(!((live && !fast) || (m_hold > 0 && !m_held_fast))));
    chk("R10 fiq_n model", int'(fiq_n), int'(!((live && fast) || (m_hold > 0 && m_held_fast))));
    chk("R8 running model", int'(running_prio), m_run);
    chk("R4 ack_id model", int'(ack_id), m_ack);
    chk("R11 hppi model", int'(hppi_id), m_hppi);
    chk("R4 act_vld model", int'(act_vld), int'(m_actv));
    if (m_actv) chk("R4 act_id model", int'(act_id), m_acti);
    chk("R6 deact_vld model", int'(deact_vld), int'(m_dv));
    if (m_dv) chk("R6 deact_id model", int'(deact_id), m_di);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) compare_model();
    end
  endtask

  task automatic offer(input bit v, input int id, input int pr, input bit g0);
    hp_valid = v; hp_id = 10'(id); hp_prio = 8'(pr); hp_grp0 = g0;
  endtask

  task automatic do_ack();  ack_rd = 1; tick(1); ack_rd = 0; endtask
  task automatic do_eoi(input int id); eoi_wr = 1; eoi_id = 10'(id); tick(1); eoi_wr = 0; endtask
  task automatic do_dir(input int id); dir_wr = 1; dir_id = 10'(id); tick(1); dir_wr = 0; endtask
  task automatic do_ctl(input bit s, input bit f);
    ctl_wr = 1; ctl_split = s; ctl_fiq_en = f; tick(1); ctl_wr = 0;
  endtask
  task automatic do_pmr(input int v); pmr_wr = 1; pmr_val = 8'(v); tick(1); pmr_wr = 0; endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 irq_n", int'(irq_n), 1);
    chk("R1 fiq_n", int'(fiq_n), 1);
    chk("R1 running", int'(running_prio), 255);
    chk("R1 ack_id", int'(ack_id), 1023);
    chk("R1 hppi_id", int'(hppi_id), 1023);
    chk("R1 no pulses", int'(act_vld | deact_vld), 0);

    // R3 assertion latency
    do_pmr(8'hF0);
    offer(1, 5, 8'h40, 0);
    tick(14);
    chk("R3 not yet at 14", int'(irq_n), 1);
    tick(1);
    chk("R3 asserted at 15", int'(irq_n), 0);

    // R3 replacement keeps line; R11 query
    offer(1, 7, 8'h20, 0);
    tick(3);
    chk("R3 stays on replace", int'(irq_n), 0);
    hppi_rd = 1; tick(1); hppi_rd = 0;
    chk("R11 query id", int'(hppi_id), 7);
    chk("R11 no state change", int'(running_prio), 255);

    // R4 acknowledge, R5 release timing
    do_ack();
    chk("R4 ack id", int'(ack_id), 7);
    chk("R4 act pulse", int'(act_vld), 1);
    chk("R4 act id", int'(act_id), 7);
    chk("R4 running", int'(running_prio), 8'h20);
    tick(2);
    chk("R5 held 3rd cycle", int'(irq_n), 0);
    tick(1);
    chk("R5 released", int'(irq_n), 1);
    offer(1, 5, 8'h40, 0);
    tick(20);
    chk("R2 running masks", int'(irq_n), 1);

    // R6 joint completion, R8 restore
    do_eoi(7);
    chk("R6 deact pulse", int'(deact_vld), 1);
    chk("R6 deact id", int'(deact_id), 7);
    chk("R8 restored", int'(running_prio), 255);
    tick(15);
    chk("R3 reassert after drop", int'(irq_n), 0);
    do_ack();
    chk("R4 ack id5", int'(ack_id), 5);

    // R10 fast line, R7 split completion
    do_ctl(1, 1);
    offer(1, 9, 8'h10, 1);
    tick(15);
    chk("R10 fiq asserted", int'(fiq_n), 0);
    chk("R10 irq idle", int'(irq_n), 1);
    do_ack();
    chk("R4 ack id9", int'(ack_id), 9);
    offer(0, 0, 0, 0);
    tick(4);
    do_eoi(9);
    chk("R7 no deact on eoi", int'(deact_vld), 0);
    chk("R8 nested restore", int'(running_prio), 8'h40);
    do_dir(9);
    chk("R7 deact on dir", int'(deact_vld), 1);
    chk("R7 deact id", int'(deact_id), 9);
    do_eoi(5);
    chk("R8 back to idle", int'(running_prio), 255);

    // R9 empty-stack EOI ignored
    do_ctl(0, 0);
    do_eoi(3);
    chk("R9 no deact", int'(deact_vld), 0);
    chk("R9 running same", int'(running_prio), 255);

    // R4 refused acknowledge
    do_ack();
    chk("R4 spurious", int'(ack_id), 1023);
    chk("R4 no act", int'(act_vld), 0);

    // R2 mask boundary
    do_pmr(8'h30);
    offer(1, 12, 8'h30, 0);
    tick(30);
    chk("R2 equal to mask", int'(irq_n), 1);
    offer(1, 12, 8'h2F, 0);
    tick(15);
    chk("R2 below mask", int'(irq_n), 0);
    offer(0, 0, 0, 0);
    tick(5);

    // R12 stack depth
    do_pmr(8'hFF);
    for (int k = 0; k < 8; k++) begin
      offer(1, 20 + k, 8'h80 - 8'h10 * k, 0);
      do_ack();
      chk("R12 nest push", int'(running_prio), 8'h80 - 8'h10 * k);
    end
    offer(1, 40, 8'h08, 0);
    tick(20);
    chk("R12 full never signals", int'(irq_n), 1);
    do_ack();
    chk("R12 full refuses", int'(ack_id), 1023);
    chk("R12 running kept", int'(running_prio), 8'h10);
    offer(0, 0, 0, 0);
    do_dir(21);
    chk("R7 dir ignored joint", int'(deact_vld), 0);
    for (int k = 7; k >= 0; k--) do_eoi(20 + k);
    chk("R8 unwound", int'(running_prio), 255);
    tick(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule